// File: doc/BRIEF.md
# Two-Channel Echo Canceller Control Register Bank

This block holds the control and status registers of a two-channel echo-canceller controller. A host reaches it over a plain parallel bus that carries an address, write data, a write strobe, a read strobe and registered read data. Each channel has two 8-bit control registers and one status register. The control bits go straight out to the signal-processing datapath: tone-detect disable, phase-reversal ignore, non-linear processor disable, automatic tone bypass, narrow-band detector disable, high-pass filter bypass, and one mute each for the send and receive outputs.

Channel 0 control registers take a new value on a single write. Channel 1 control registers are guarded. A value reaches such a register only when the host writes the same value to the same register twice in a row, and the spacing between the two strobes falls inside a window set in clock cycles. The bank also builds the status bytes from the detector flags, a bypass request for each channel, a shared power-down signal for the tone processors, and the muted PCM outputs.

Top module: `dual_chan_ctl_bank`

## Requirements
- R1: A write to channel 0 control register 1 (offset 0x00) or control register 2 (offset 0x01) reaches the register and its outputs at the clock edge that samples the strobe.
- R2: A channel 1 control register (0x20 or 0x21) changes only when a second write to the same address with the same data comes d cycles after the first write, where MIN_CYC <= d <= MAX_CYC and d counts clock edges between the two strobes. A lone write leaves the register unchanged.
- R3: A matching second write with d < MIN_CYC does not commit. It becomes the first write of a new pair.
- R4: A second write with d > MAX_CYC does not commit. The pending first write expires after MAX_CYC cycles.
- R5: A second write to the same address with different data does not commit. It becomes the first write of a new pair.
- R6: Any write to a different address between the two writes of a pair cancels the pending write.
- R7: Control register 2 bits map to outputs as follows: 7 tone-detect disable, 6 phase-reversal ignore, 5 NLP disable, 4 auto tone bypass, 3 narrow-band detector disable, 2 high-pass bypass, 1 send mute, 0 receive mute.
- R8: A status register (0x02 or 0x22) reads as follows: bit 6 is the raw tone flag, bit 5 is double-talk, bit 1 is the tone flag ANDed with auto tone bypass, and bit 0 is narrow-band. Bits 7, 4, 3 and 2 read 0. Unmapped addresses read 0x00.
- R9: Read data appears on the clock edge after the read strobe is sampled. It shows the committed value, never a pending one. Reads change no register and no pending state.
- R10: The tone power-down output is high exactly when both channels' tone-detect disable bits are set.
- R11: A channel's bypass request is high exactly when its auto tone bypass bit and its tone flag are both high.
- R12: A set send or receive mute bit replaces that channel's PCM output with the QUIET code. Otherwise the input passes through unchanged.
- R13: After reset all registers read 0x00 and all control outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register address; bit 5 selects the channel |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| tone_det_i | input | 2 | Raw 2100 Hz tone flag per channel |
| dtalk_i | input | 2 | Double-talk flag per channel |
| nb_det_i | input | 2 | Narrow-band flag per channel |
| sout_i | input | 2x PCM_W | Send-side PCM from the datapath |
| rout_i | input | 2x PCM_W | Receive-side PCM from the datapath |
| sout_o | output | 2x PCM_W | Send-side PCM after muting |
| rout_o | output | 2x PCM_W | Receive-side PCM after muting |
| ctl1_o | output | 2x8 | Control register 1 contents per channel |
| tone_off_o | output | 2 | Tone-detect disable |
| phase_ign_o | output | 2 | Phase-reversal ignore |
| nlp_off_o | output | 2 | NLP disable |
| auto_byp_o | output | 2 | Auto tone bypass enable |
| nb_off_o | output | 2 | Narrow-band detector disable |
| hpf_byp_o | output | 2 | High-pass filter bypass |
| mute_s_o | output | 2 | Send mute |
| mute_r_o | output | 2 | Receive mute |
| tone_pwrdn_o | output | 1 | Shared tone-processor power-down |
| bypass_req_o | output | 2 | Per-channel bypass request |

## Verification
The bench builds the bank with MIN_CYC = 8, MAX_CYC = 40 and QUIET = 0xD5. With these values every window edge fits in a short run. Pairs are placed at spacings of 7, 8, 10, 40 and 41 cycles, which hits both boundaries and the cases just outside them. A quiet code other than the default 0xFF cannot be confused with an input that happens to be all ones. The default channel mask leaves channel 0 unguarded and channel 1 guarded, so both variants are exercised in one build.

// File: rtl/dwg_pkg.sv
package dwg_pkg;
   localparam int NCH     = 2;
   localparam int REG_W   = 8;
   localparam int CH_BIT  = 5;
   localparam logic [4:0] OFS_CTL1 = 5'h00;
   localparam logic [4:0] OFS_CTL2 = 5'h01;
   localparam logic [4:0] OFS_STAT = 5'h02;

   typedef struct packed {
      logic tone_off;
      logic phase_ign;
      logic nlp_off;
      logic auto_byp;
      logic nb_off;
      logic hpf_byp;
      logic mute_s;
      logic mute_r;
   } ctl2_t;

   function automatic logic [REG_W-1:0] stat_pack(input logic tone, input logic dtalk,
                                                  input logic nb, input logic auto_byp);
      return {1'b0, tone, dtalk, 3'b000, tone & auto_byp, nb};
   endfunction
endpackage

// File: rtl/dwg_guard.sv
module dwg_guard #(
   parameter int MIN_CYC = 70,
   parameter int MAX_CYC = 4000,
   parameter int DW      = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_i,
   input  logic          hit_i,
   input  logic          sel_i,
   input  logic [DW-1:0] wdata_i,
   output logic          commit_o,
   output logic          csel_o,
   output logic [DW-1:0] cdata_o
);
   localparam int CW = $clog2(MAX_CYC + 1);

   if (MIN_CYC < 1)       begin : g_chk_min $error("MIN_CYC must be at least 1"); end
   if (MAX_CYC < MIN_CYC) begin : g_chk_max $error("MAX_CYC must not be below MIN_CYC"); end

   logic          pend_q;
   logic          psel_q;
   logic [DW-1:0] pdata_q;
   logic [CW-1:0] cnt_q;
   logic          match;

   assign match    = pend_q && (psel_q == sel_i) && (pdata_q == wdata_i)
                     && (cnt_q >= CW'(MIN_CYC));
   assign commit_o = wr_i && hit_i && match;
   assign csel_o   = sel_i;
   assign cdata_o  = wdata_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         psel_q  <= 1'b0;
         pdata_q <= '0;
         cnt_q   <= '0;
      end else if (wr_i) begin
         if (hit_i && !match) begin
            pend_q  <= 1'b1;
            psel_q  <= sel_i;
            pdata_q <= wdata_i;
            cnt_q   <= CW'(1);
         end else begin
            pend_q  <= 1'b0;
         end
      end else if (pend_q) begin
         if (cnt_q == CW'(MAX_CYC)) pend_q <= 1'b0;
         else                       cnt_q  <= cnt_q + 1'b1;
      end
   end

   assert_pending_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> (cnt_q >= CW'(1)) && (cnt_q <= CW'(MAX_CYC)));

   assert_expire_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !wr_i && cnt_q == CW'(MAX_CYC)) |=> !pend_q);
endmodule

// File: rtl/dwg_chan.sv
module dwg_chan
   import dwg_pkg::*;
#(
   parameter bit   GUARDED = 1'b0,
   parameter int   MIN_CYC = 70,
   parameter int   MAX_CYC = 4000,
   parameter int   PCM_W   = 8,
   parameter logic [PCM_W-1:0] QUIET = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic             chan_sel_i,
   input  logic [4:0]       ofs_i,
   input  logic [REG_W-1:0] wdata_i,
   input  logic             tone_i,
   input  logic             dtalk_i,
   input  logic             nb_i,
   input  logic [PCM_W-1:0] sout_i,
   input  logic [PCM_W-1:0] rout_i,
   output logic [PCM_W-1:0] sout_o,
   output logic [PCM_W-1:0] rout_o,
   output logic [REG_W-1:0] ctl1_o,
   output ctl2_t            ctl2_o,
   output logic [REG_W-1:0] rd_o,
   output logic             byp_req_o
);
   logic             hit, sel;
   logic             commit, csel;
   logic [REG_W-1:0] cdata;
   logic [REG_W-1:0] ctl1_q;
   ctl2_t            ctl2_q;

   assign hit = chan_sel_i && ((ofs_i == OFS_CTL1) || (ofs_i == OFS_CTL2));
   assign sel = (ofs_i == OFS_CTL2);

   if (GUARDED) begin : g_guard
      dwg_guard #(.MIN_CYC(MIN_CYC), .MAX_CYC(MAX_CYC), .DW(REG_W)) guard_i (
         .clk(clk), .rst_n(rst_n), .wr_i(wr_i), .hit_i(hit), .sel_i(sel),
         .wdata_i(wdata_i), .commit_o(commit), .csel_o(csel), .cdata_o(cdata));
   end else begin : g_direct
      assign commit = wr_i && hit;
      assign csel   = sel;
      assign cdata  = wdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl1_q <= '0;
         ctl2_q <= '0;
      end else if (commit) begin
         if (csel) ctl2_q <= ctl2_t'(cdata);
         else      ctl1_q <= cdata;
      end
   end

   always_comb begin
      unique case (ofs_i)
         OFS_CTL1: rd_o = ctl1_q;
         OFS_CTL2: rd_o = ctl2_q;
         OFS_STAT: rd_o = stat_pack(tone_i, dtalk_i, nb_i, ctl2_q.auto_byp);
         default:  rd_o = '0;
      endcase
   end

   assign ctl1_o    = ctl1_q;
   assign ctl2_o    = ctl2_q;
   assign byp_req_o = ctl2_q.auto_byp && tone_i;
   assign sout_o    = ctl2_q.mute_s ? QUIET : sout_i;
   assign rout_o    = ctl2_q.mute_r ? QUIET : rout_i;

   assert_ctl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(ctl2_q) && $stable(ctl1_q));

   assert_commit_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> wr_i && chan_sel_i);
endmodule

// File: rtl/dual_chan_ctl_bank.sv
module dual_chan_ctl_bank
   import dwg_pkg::*;
#(
   parameter int   ADDR_W     = 6,
   parameter int   PCM_W      = 8,
   parameter int   MIN_CYC    = 70,
   parameter int   MAX_CYC    = 4000,
   parameter logic [1:0] GUARD_MASK = 2'b10,
   parameter logic [PCM_W-1:0] QUIET = '1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [7:0]                 wdata,
   input  logic                       wr_en,
   input  logic                       rd_en,
   output logic [7:0]                 rdata,
   input  logic [1:0]                 tone_det_i,
   input  logic [1:0]                 dtalk_i,
   input  logic [1:0]                 nb_det_i,
   input  logic [1:0][PCM_W-1:0]      sout_i,
   input  logic [1:0][PCM_W-1:0]      rout_i,
   output logic [1:0][PCM_W-1:0]      sout_o,
   output logic [1:0][PCM_W-1:0]      rout_o,
   output logic [1:0][7:0]            ctl1_o,
   output logic [1:0]                 tone_off_o,
   output logic [1:0]                 phase_ign_o,
   output logic [1:0]                 nlp_off_o,
   output logic [1:0]                 auto_byp_o,
   output logic [1:0]                 nb_off_o,
   output logic [1:0]                 hpf_byp_o,
   output logic [1:0]                 mute_s_o,
   output logic [1:0]                 mute_r_o,
   output logic                       tone_pwrdn_o,
   output logic [1:0]                 bypass_req_o
);
   if (ADDR_W < CH_BIT + 1) begin : g_chk_aw $error("ADDR_W too narrow for the channel bit"); end
   if (PCM_W < 1)           begin : g_chk_pw $error("PCM_W must be positive"); end

   logic                 hi_ok;
   logic [4:0]           ofs;
   ctl2_t [NCH-1:0]      ctl2_w;
   logic [NCH-1:0][7:0]  rd_w;

   assign hi_ok = ((addr >> (CH_BIT + 1)) == '0);
   assign ofs   = addr[4:0];

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      dwg_chan #(
         .GUARDED(GUARD_MASK[c]), .MIN_CYC(MIN_CYC), .MAX_CYC(MAX_CYC),
         .PCM_W(PCM_W), .QUIET(QUIET)
      ) chan_i (
         .clk(clk), .rst_n(rst_n), .wr_i(wr_en),
         .chan_sel_i(hi_ok && (addr[CH_BIT] == 1'(c))),
         .ofs_i(ofs), .wdata_i(wdata),
         .tone_i(tone_det_i[c]), .dtalk_i(dtalk_i[c]), .nb_i(nb_det_i[c]),
         .sout_i(sout_i[c]), .rout_i(rout_i[c]),
         .sout_o(sout_o[c]), .rout_o(rout_o[c]),
         .ctl1_o(ctl1_o[c]), .ctl2_o(ctl2_w[c]), .rd_o(rd_w[c]),
         .byp_req_o(bypass_req_o[c]));

      assign tone_off_o[c]  = ctl2_w[c].tone_off;
      assign phase_ign_o[c] = ctl2_w[c].phase_ign;
      assign nlp_off_o[c]   = ctl2_w[c].nlp_off;
      assign auto_byp_o[c]  = ctl2_w[c].auto_byp;
      assign nb_off_o[c]    = ctl2_w[c].nb_off;
      assign hpf_byp_o[c]   = ctl2_w[c].hpf_byp;
      assign mute_s_o[c]    = ctl2_w[c].mute_s;
      assign mute_r_o[c]    = ctl2_w[c].mute_r;

      assert_mute_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
         (mute_s_o[c] |-> sout_o[c] == QUIET) and (mute_r_o[c] |-> rout_o[c] == QUIET));
   end

   assign tone_pwrdn_o = &tone_off_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= hi_ok ? rd_w[addr[CH_BIT]] : '0;
   end

   assert_rsvd_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && ofs == OFS_STAT) |=> (rdata & 8'h9C) == 8'h00);

   assert_read_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en) |=> $stable(ctl1_o) && $stable(ctl2_w));

   assert_pwrdn_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tone_pwrdn_o |-> (tone_off_o == 2'b11));
endmodule

// File: tb/dual_chan_ctl_bank_tb.sv
module dual_chan_ctl_bank_tb_top;
   localparam logic [7:0] QV = 8'hD5;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [5:0]      addr = '0;
   logic [7:0]      wdata = '0;
   logic            wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0]      rdata;
   logic [1:0]      tone = '0, dtalk = '0, nb = '0;
   logic [1:0][7:0] s_in, r_in, s_out, r_out, ctl1;
   logic [1:0]      tone_off, phase_ign, nlp_off, auto_byp, nb_off, hpf_byp, mute_s, mute_r, byp;
   logic            pwrdn;

   int n_chk = 0, n_fail = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic       rd_seen = 1'b0;

   always #2.5 clk = ~clk;

   dual_chan_ctl_bank #(.MIN_CYC(8), .MAX_CYC(40), .QUIET(QV)) dut_i (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en),
      .rdata(rdata), .tone_det_i(tone), .dtalk_i(dtalk), .nb_det_i(nb),
      .sout_i(s_in), .rout_i(r_in), .sout_o(s_out), .rout_o(r_out), .ctl1_o(ctl1),
      .tone_off_o(tone_off), .phase_ign_o(phase_ign), .nlp_off_o(nlp_off),
      .auto_byp_o(auto_byp), .nb_off_o(nb_off), .hpf_byp_o(hpf_byp),
      .mute_s_o(mute_s), .mute_r_o(mute_r), .tone_pwrdn_o(pwrdn), .bypass_req_o(byp));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // monitor: pops one expected item per completed read
   always @(posedge clk) rd_seen <= rd_en;
   always @(negedge clk) begin
      if (rd_seen) begin
         if (exp_q.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R9: unexpected read data %0h, expected none", rdata);
         end else begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string      t = tag_q.pop_front();
            check(t, 32'(rdata), 32'(e));
         end
      end
   end

   // driver tasks start and end on a falling edge
   task automatic wr(input logic [5:0] a, input logic [7:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, input logic [7:0] e, input string tag);
      addr = a; rd_en = 1'b1;
      exp_q.push_back(e); tag_q.push_back(tag);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      for (int i = 0; i < 200000; i++) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      s_in = {8'h34, 8'h12};
      r_in = {8'h78, 8'h56};
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R13 reset state
      rd(6'h00, 8'h00, "R13 ctl1 A"); rd(6'h01, 8'h00, "R13 ctl2 A");
      rd(6'h02, 8'h00, "R13 stat A"); rd(6'h20, 8'h00, "R13 ctl1 B");
      rd(6'h21, 8'h00, "R13 ctl2 B"); rd(6'h22, 8'h00, "R13 stat B");
      check("R13 ctl outputs", {tone_off, phase_ign, nlp_off, auto_byp, nb_off, hpf_byp, mute_s, mute_r}, 0);
      check("R13 pwrdn", pwrdn, 0);
      check("R12 pass sout", s_out, s_in);
      // R1 single write on channel 0
      wr(6'h01, 8'hA5);
      check("R1 R7 tone_off", tone_off, 2'b01);
      check("R7 nlp/hpf/mute_r", {nlp_off, hpf_byp, mute_r}, 6'b01_01_01);
      check("R7 phase/auto/nb/mute_s", {phase_ign, auto_byp, nb_off, mute_s}, 0);
      check("R12 rout A quiet", r_out[0], QV);
      rd(6'h01, 8'hA5, "R1 ctl2 A readback");
      wr(6'h00, 8'h3C);
      check("R1 ctl1 A", ctl1[0], 8'h3C);
      rd(6'h00, 8'h3C, "R1 ctl1 A readback");
      // R2 pair at MAX spacing, read of pending value in between
      wr(6'h21, 8'h5A);
      rd(6'h21, 8'h00, "R9 pending not visible");
      idle(38);
      wr(6'h21, 8'h5A);
      check("R2 R7 B bits", {phase_ign[1], auto_byp[1], nb_off[1], mute_s[1], tone_off[1]}, 5'b11110);
      check("R12 sout B quiet", s_out[1], QV);
      rd(6'h21, 8'h5A, "R2 ctl2 B at MAX");
      // R2 pair at MIN spacing on ctl1
      wr(6'h20, 8'h11);
      check("R2 lone write", ctl1[1], 8'h00);
      idle(7);
      wr(6'h20, 8'h11);
      check("R2 ctl1 B at MIN", ctl1[1], 8'h11);
      // R3 too early, second becomes first
      wr(6'h21, 8'hC3);
      idle(6);
      wr(6'h21, 8'hC3);
      rd(6'h21, 8'h5A, "R3 early pair");
      idle(6);
      wr(6'h21, 8'hC3);
      rd(6'h21, 8'hC3, "R3 restarted pair");
      check("R3 tone_off B", tone_off[1], 1'b1);
      // R4 too late
      wr(6'h21, 8'h0F);
      idle(40);
      wr(6'h21, 8'h0F);
      rd(6'h21, 8'hC3, "R4 late pair");
      // R6 cancel by unmapped write
      wr(6'h05, 8'h00);
      idle(8);
      wr(6'h21, 8'h0F);
      rd(6'h21, 8'hC3, "R6 cancel unmapped");
      wr(6'h05, 8'h00);
      // R5 data mismatch
      wr(6'h21, 8'h0F);
      idle(9);
      wr(6'h21, 8'hF0);
      rd(6'h21, 8'hC3, "R5 data mismatch");
      idle(8);
      wr(6'h21, 8'hF0);
      rd(6'h21, 8'hF0, "R5 restarted pair");
      // R6 cancel by other channel write
      wr(6'h21, 8'h33);
      wr(6'h01, 8'h00);
      idle(8);
      wr(6'h21, 8'h33);
      rd(6'h21, 8'hF0, "R6 cancel other channel");
      wr(6'h05, 8'h00);
      check("R7 B F0", {tone_off[1], phase_ign[1], nlp_off[1], auto_byp[1], nb_off[1], hpf_byp[1], mute_s[1], mute_r[1]}, 8'hF0);
      check("R12 sout B pass", s_out[1], s_in[1]);
      // R10 power-down
      check("R10 one set", pwrdn, 1'b0);
      wr(6'h01, 8'h80);
      check("R10 both set", pwrdn, 1'b1);
      wr(6'h01, 8'h10);
      check("R10 cleared", pwrdn, 1'b0);
      // R8 R11 status and bypass
      tone = 2'b11; dtalk = 2'b10; nb = 2'b10;
      idle(1);
      check("R11 both bypass", byp, 2'b11);
      rd(6'h22, 8'h63, "R8 stat B");
      rd(6'h02, 8'h42, "R8 stat A");
      tone = 2'b10; nb = 2'b01;
      idle(1);
      check("R11 A no tone", byp, 2'b10);
      rd(6'h02, 8'h01, "R8 stat A nb");
      rd(6'h22, 8'h62, "R8 stat B");
      rd(6'h05, 8'h00, "R8 unmapped");
      rd(6'h3F, 8'h00, "R8 unmapped B");
      // R12 mute channel 0
      wr(6'h01, 8'h03);
      check("R12 sout A quiet", s_out[0], QV);
      check("R12 rout A quiet", r_out[0], QV);
      check("R12 rout B pass", r_out[1], r_in[1]);
      idle(2);
      check("R9 queue drained", exp_q.size(), 0);
      finish_run();
   end
endmodule